// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small register-transfer datapath: a set of equal-width storage registers that exchange words over one shared bus. A select input picks the single source whose word drives the bus in a cycle. That source is either one of the registers or an external parallel-load input. Every register has its own load enable. Any subset of registers can capture the bus word on the same rising clock edge, but all of them get the same word.

The clock runs freely to every flip-flop. A register that is not loading keeps its word through a feedback multiplexer in front of its flip-flops, so no clock gating is used. Transfers from different sources must therefore happen in separate cycles. The bus is combinational, so a word loaded on one edge can be the bus source in the very next cycle. The register width and the register count are parameters, with defaults of 8 bits and 3 registers. The select is 2 bits wide.

Top module: `sbus_xfer_datapath`

## Requirements
- R1: Driving rst_ni low clears every register to zero at once, without waiting for a clock edge, and the registers stay at zero while rst_ni is low.
- R2: When src_sel_i holds a value k below the register count (0, 1 or 2 by default), bus_o shows register k in the same cycle, with no clock edge in between.
- R3: When src_sel_i holds 3 (the register count), bus_o shows ext_data_i in the same cycle.
- R4: When bit k of load_en_i is 1 at a rising clock edge, register k holds the bus_o value from just before that edge. Register k is read from reg_q_o bits [k*WIDTH +: WIDTH].
- R5: When bit k of load_en_i is 0 at a rising clock edge, register k keeps its value, whatever the bus carries.
- R6: When several load enable bits are 1 on one edge, every enabled register captures the same bus word on that edge.
- R7: A register that is both the selected source and an enabled destination reloads its own word, so its value does not change.
- R8: A word loaded on one edge is on the bus in the next cycle when that register is selected, so a chain of transfers moves the word forward by one register per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 2 | Bus source: 0..2 selects a register, 3 selects ext_data_i |
| load_en_i | input | 3 | One load enable per register; bit k belongs to register k |
| ext_data_i | input | 8 | External parallel-load word |
| reg_q_o | output | 24 | All register values; register k is at bits [k*8 +: 8] |
| bus_o | output | 8 | Current shared bus word |

## Verification
The bench goes after cases where a register is both source and destination, where several registers load at once, and where a word is moved through a chain of registers on back-to-back cycles. A design that gated loads badly would corrupt the source register on a self-reload. A design that fed each register its own path would let the enabled destinations diverge. A design that registered the bus would move stale words one cycle late along the chain. The bench also selects the external input with every load enable low: a broken hold path shows up there as registers that pick up the bus word. It also pulls the asynchronous reset low between clock edges: a synchronous or missing clear leaves nonzero words on the outputs.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_REGS  = 3;

  // Source codes for the default 3-register build.
  typedef enum logic [1:0] {
    SRC_W0  = 2'd0,
    SRC_W1  = 2'd1,
    SRC_W2  = 2'd2,
    SRC_EXT = 2'd3
  } src_sel_e;
endpackage

// File: rtl/sbus_hold_cell.sv
`timescale 1ns/1ps
module sbus_hold_cell #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_d;

  // Feedback mux: hold on load_i=0, no clock gating.
  assign q_d = load_i ? d_i : q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  a_r4_load_takes_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(d_i)));

  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/sbus_src_mux.sv
`timescale 1ns/1ps
module sbus_src_mux #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned NUM_REGS = 3,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS + 1)
) (
  input  logic [NUM_REGS*WIDTH-1:0] regs_i,
  input  logic [WIDTH-1:0]          ext_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [WIDTH-1:0]          bus_o
);
  // Codes at or above NUM_REGS pick the external word.
  always_comb begin
    bus_o = ext_i;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (sel_i == SEL_W'(k)) bus_o = regs_i[k*WIDTH +: WIDTH];
    end
  end
endmodule

// File: rtl/sbus_xfer_datapath.sv
`timescale 1ns/1ps
module sbus_xfer_datapath
  import sbus_pkg::*;
#(
  parameter int unsigned WIDTH    = DEF_WIDTH,
  parameter int unsigned NUM_REGS = DEF_REGS,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SEL_W-1:0]          src_sel_i,
  input  logic [NUM_REGS-1:0]       load_en_i,
  input  logic [WIDTH-1:0]          ext_data_i,
  output logic [NUM_REGS*WIDTH-1:0] reg_q_o,
  output logic [WIDTH-1:0]          bus_o
);
  logic [NUM_REGS*WIDTH-1:0] reg_q;
  logic [WIDTH-1:0]          bus;

  sbus_src_mux #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS)) u_src_mux (
    .regs_i (reg_q),
    .ext_i  (ext_data_i),
    .sel_i  (src_sel_i),
    .bus_o  (bus)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    sbus_hold_cell #(.WIDTH(WIDTH)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_en_i[g]),
      .d_i    (bus),
      .q_o    (reg_q[g*WIDTH +: WIDTH])
    );

    a_r2_reg_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_sel_i == SEL_W'(g)) |-> (bus_o == reg_q_o[g*WIDTH +: WIDTH]));

    a_r7_self_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((src_sel_i == SEL_W'(g)) && load_en_i[g]) |=> $stable(reg_q_o[g*WIDTH +: WIDTH]));
  end

  assign reg_q_o = reg_q;
  assign bus_o   = bus;

  a_r3_ext_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i >= SEL_W'(NUM_REGS)) |-> (bus_o == ext_data_i));

  a_r6_same_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i[0] && load_en_i[NUM_REGS-1]) |=>
      (reg_q_o[WIDTH-1:0] == reg_q_o[(NUM_REGS-1)*WIDTH +: WIDTH]));
endmodule

// File: tb/tb_sbus_xfer_datapath.sv
`timescale 1ns/1ps
module tb_sbus_xfer_datapath;
  localparam int W = 8;
  localparam int N = 3;

  typedef struct {
    logic [W-1:0] exp_bus;
    logic [W-1:0] exp_reg [N];
    string        bus_req;
    string        reg_req;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   src_sel_i = 2'd0;
  logic [N-1:0] load_en_i = '0;
  logic [W-1:0] ext_data_i = '0;
  logic [N*W-1:0] reg_q_o;
  logic [W-1:0]   bus_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [W-1:0] model [N];
  item_t q[$];

  sbus_xfer_datapath dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_sel_i(src_sel_i),
    .load_en_i(load_en_i), .ext_data_i(ext_data_i),
    .reg_q_o(reg_q_o), .bus_o(bus_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called at a negedge; drives one cycle and queues expectations.
  task automatic xfer(logic [1:0] sel, logic [N-1:0] ld, logic [W-1:0] ext,
                      string reg_req);
    item_t it;
    src_sel_i  = sel;
    load_en_i  = ld;
    ext_data_i = ext;
    it.exp_bus = (sel < 2'(N)) ? model[sel] : ext;
    it.bus_req = (sel < 2'(N)) ? "R2" : "R3";
    for (int k = 0; k < N; k++) if (ld[k]) model[k] = it.exp_bus;
    for (int k = 0; k < N; k++) it.exp_reg[k] = model[k];
    it.reg_req = reg_req;
    q.push_back(it);
    @(negedge clk_i);
  endtask

  // Monitor: bus just before the edge, registers just after it.
  initial begin
    forever begin
      @(negedge clk_i);
      #4;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.bus_req, bus_o, it.exp_bus);
        @(posedge clk_i);
        #1;
        for (int k = 0; k < N; k++)
          check(it.reg_req, reg_q_o[k*W +: W], it.exp_reg[k]);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    for (int k = 0; k < N; k++) model[k] = '0;
    #3;
    for (int k = 0; k < N; k++) check("R1", reg_q_o[k*W +: W], '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    xfer(2'd3, 3'b001, 8'hA5, "R4");   // external into register 0
    xfer(2'd3, 3'b110, 8'h3C, "R6");   // two destinations at once
    xfer(2'd3, 3'b000, 8'hFF, "R5");   // no load: all hold
    xfer(2'd0, 3'b000, 8'h00, "R5");
    xfer(2'd0, 3'b010, 8'h00, "R4");   // register 0 -> register 1
    xfer(2'd1, 3'b010, 8'h77, "R7");   // self reload
    xfer(2'd2, 3'b111, 8'h00, "R7");   // source also among destinations
    xfer(2'd3, 3'b001, 8'h11, "R8");   // chain start
    xfer(2'd0, 3'b100, 8'hEE, "R8");   // bus must show 11 now
    xfer(2'd2, 3'b010, 8'hDD, "R8");
    xfer(2'd3, 3'b111, 8'h5A, "R6");

    lfsr = 8'h1D;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      xfer(lfsr[1:0], lfsr[4:2], lfsr ^ 8'(i * 37), "R4");
    end
    src_sel_i = 2'd0;
    load_en_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);

    // Asynchronous clear between edges.
    #2;
    rst_ni = 1'b0;
    #1;
    for (int k = 0; k < N; k++) check("R1", reg_q_o[k*W +: W], '0);
    @(posedge clk_i);
    #1;
    for (int k = 0; k < N; k++) check("R1", reg_q_o[k*W +: W], '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < N; k++) model[k] = '0;
    @(negedge clk_i);
    xfer(2'd1, 3'b001, 8'h99, "R1");   // register 1 still zero after clear
    @(negedge clk_i);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule